// File: doc/BRIEF.md
# Sixteen-Channel DMA Programming Port

This block is the host-side programming front of a sixteen-channel DMA controller. The host reaches it through two byte-wide write paths and one read path. A byte on the command path names an operation and a channel. The bytes that follow on the shared data path fill or drain that channel's registers one byte at a time. No register has an address of its own. A byte pointer inside the block, restarted by every command byte, decides which byte of the register the next data access touches.

Each channel holds a 24-bit memory address, a 16-bit unit count, a 16-bit I/O port address, a mode byte and a mask bit. A transfer engine, which is not part of this block, raises a per-channel request strobe once for each unit it moves. Each accepted request advances the channel's address and lowers its count. A terminal-count flag marks the point where the count runs past zero. A side query port lets the engine read any channel's registers at once. Every host path is always ready, so no access is ever held off and no back-pressure exists. A strobe that is high at a rising edge is consumed at that edge. When a command strobe and a data strobe are both high, the command wins.

Top module: `dma_cmd_port`

## Requirements
- R1: A command byte carries the opcode in bits 7:4 and the channel number in bits 3:0. Every command byte sends the byte pointer back to byte 0.
- R2: Opcode 0x2 loads the memory address from the next three data bytes, in the order bits 7:0, then bits 15:8, then bits 23:16.
- R3: Opcode 0x4 loads the count from the next two data bytes, low byte first. The value is the number of units minus one. Loading a count byte clears the channel's terminal-count flag.
- R4: Opcode 0x0 loads the I/O port address from the next two data bytes, low byte first. The value appears on q_io_port.
- R5: Opcode 0x7 loads the mode byte from the next data byte. Bit 2 enables transfers, bit 3 selects read (1) or write (0), bit 0 targets an I/O register, and bit 6 selects 16-bit units. The byte appears on q_mode.
- R6: Opcode 0x9 masks the named channel and opcode 0xA unmasks it. Unmasking leaves all programmed registers unchanged. After reset every channel is masked and every register is zero.
- R7: Opcode 0x3 makes rdata present the address bytes, low byte first. Opcode 0x5 does the same for the two count bytes. Each dat_re moves on to the next byte. Once the register's bytes are used up, rdata is 0x00. With any other opcode current, rdata is also 0x00.
- R8: Data bytes beyond the width of the current register are ignored. Data writes are also ignored while a readback or non-loading opcode is current.
- R9: chan_active[n] is high exactly when channel n is unmasked, has mode bit 2 set and has no terminal count. A request on a channel that is not active changes nothing.
- R10: An accepted request lowers the count by one. It raises the address by 1, or by 2 when mode bit 6 is set.
- R11: When an accepted request finds the count at zero, the count wraps to 0xFFFF, the terminal-count flag is set and the channel stops accepting requests.
- R12: Opcode 0xD masks all channels. The opcodes 0x1, 0x6, 0x8, 0xB, 0xC, 0xE and 0xF change no channel state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Command byte strobe |
| dat_we | input | 1 | Data byte write strobe |
| dat_re | input | 1 | Data byte read strobe; advances the readback pointer |
| wdata | input | 8 | Command or data byte |
| rdata | output | 8 | Byte the next read returns |
| xfer_req | input | NCH | Per-channel unit-moved strobe |
| chan_active | output | NCH | Channel may accept requests |
| term_cnt | output | NCH | Terminal-count flags |
| q_chan | input | 4 | Channel selected for the query outputs |
| q_mode | output | 8 | Mode byte of q_chan |
| q_io_port | output | 16 | I/O port address of q_chan |
| q_addr | output | 24 | Current address of q_chan |
| q_count | output | 16 | Remaining count of q_chan |

## Verification
The hardest condition to reach is the wrap at the terminal count. It only occurs after a channel has been fully programmed, unmasked and enabled, and has then received exactly count-plus-one requests. The stimulus therefore programs a channel with a small count in 16-bit mode and steps it one request at a time, checking the address and count after each step. It then sends one extra request to show that nothing moves after the wrap. A second channel is stepped while it is masked and while it is disabled, to show that those requests have no effect.

// File: rtl/dma_cmd_pkg.sv
package dma_cmd_pkg;
  localparam int unsigned CH_W     = 4;
  localparam int unsigned ADDR_W   = 24;
  localparam int unsigned CNT_W    = 16;
  localparam int unsigned IO_W     = 16;
  localparam int unsigned MODE_W   = 8;
  localparam int unsigned ADDR_NB  = ADDR_W / 8;
  localparam int unsigned CNT_NB   = CNT_W / 8;
  localparam int unsigned IO_NB    = IO_W / 8;

  localparam logic [3:0] OP_LD_IO   = 4'h0;
  localparam logic [3:0] OP_IDLE    = 4'h1;
  localparam logic [3:0] OP_LD_ADDR = 4'h2;
  localparam logic [3:0] OP_RD_ADDR = 4'h3;
  localparam logic [3:0] OP_LD_CNT  = 4'h4;
  localparam logic [3:0] OP_RD_CNT  = 4'h5;
  localparam logic [3:0] OP_LD_MODE = 4'h7;
  localparam logic [3:0] OP_MASK    = 4'h9;
  localparam logic [3:0] OP_UNMASK  = 4'hA;
  localparam logic [3:0] OP_MASKALL = 4'hD;

  localparam int unsigned MB_IO   = 0;
  localparam int unsigned MB_EN   = 2;
  localparam int unsigned MB_RD   = 3;
  localparam int unsigned MB_WIDE = 6;

  typedef enum logic [1:0] {
    RS_IO   = 2'd0,
    RS_ADDR = 2'd1,
    RS_CNT  = 2'd2,
    RS_MODE = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic     en;
    reg_sel_e sel;
    logic [1:0] idx;
    logic [7:0] data;
  } byte_wr_t;

  function automatic logic [1:0] op_len(input logic [3:0] op);
    case (op)
      OP_LD_IO:   return 2'(IO_NB);
      OP_LD_ADDR: return 2'(ADDR_NB);
      OP_RD_ADDR: return 2'(ADDR_NB);
      OP_LD_CNT:  return 2'(CNT_NB);
      OP_RD_CNT:  return 2'(CNT_NB);
      OP_LD_MODE: return 2'd1;
      default:    return 2'd0;
    endcase
  endfunction

  function automatic logic is_load(input logic [3:0] op);
    return (op == OP_LD_IO) || (op == OP_LD_ADDR) ||
           (op == OP_LD_CNT) || (op == OP_LD_MODE);
  endfunction

  function automatic logic is_get(input logic [3:0] op);
    return (op == OP_RD_ADDR) || (op == OP_RD_CNT);
  endfunction

  function automatic reg_sel_e op_reg(input logic [3:0] op);
    case (op)
      OP_LD_ADDR: return RS_ADDR;
      OP_LD_CNT:  return RS_CNT;
      OP_LD_MODE: return RS_MODE;
      default:    return RS_IO;
    endcase
  endfunction
endpackage

// File: rtl/dma_cmd_decode.sv
module dma_cmd_decode
  import dma_cmd_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_we,
  input  logic            dat_we,
  input  logic            dat_re,
  input  logic [7:0]      wdata,
  output logic [3:0]      cur_op,
  output logic [CH_W-1:0] cur_ch,
  output logic [1:0]      ptr,
  output byte_wr_t        wr,
  output logic            mask_one,
  output logic            unmask_one,
  output logic            mask_all,
  output logic [CH_W-1:0] cmd_ch
);
  logic [1:0] len;
  logic       in_range;
  logic       advance;

  assign len      = op_len(cur_op);
  assign in_range = (ptr < len);
  assign advance  = !cmd_we && in_range &&
                    ((dat_we && is_load(cur_op)) || (dat_re && is_get(cur_op)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_op <= OP_IDLE;
      cur_ch <= '0;
      ptr    <= '0;
    end else if (cmd_we) begin
      cur_op <= wdata[7:4];
      cur_ch <= wdata[CH_W-1:0];
      ptr    <= '0;
    end else if (advance) begin
      ptr <= ptr + 2'd1;
    end
  end

  always_comb begin
    wr.en   = dat_we && !cmd_we && is_load(cur_op) && in_range;
    wr.sel  = op_reg(cur_op);
    wr.idx  = ptr;
    wr.data = wdata;
  end

  assign cmd_ch     = wdata[CH_W-1:0];
  assign mask_one   = cmd_we && (wdata[7:4] == OP_MASK);
  assign unmask_one = cmd_we && (wdata[7:4] == OP_UNMASK);
  assign mask_all   = cmd_we && (wdata[7:4] == OP_MASKALL);

  assert_ptr_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we |=> (ptr == 2'd0));

  assert_extra_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_we && (dat_we || dat_re) && (ptr >= op_len(cur_op))) |=> $stable(ptr));

  assert_no_write_on_cmd_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we |-> !wr.en);
endmodule

// File: rtl/dma_chan.sv
module dma_chan
  import dma_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_wr,
  input  byte_wr_t          wr,
  input  logic              mask_one,
  input  logic              unmask_one,
  input  logic              mask_all,
  input  logic              req,
  output logic [ADDR_W-1:0] addr_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic [IO_W-1:0]   io_q,
  output logic [MODE_W-1:0] mode_q,
  output logic              tc_q,
  output logic              active
);
  logic masked_q;
  logic step;
  logic [ADDR_W-1:0] addr_inc;

  assign active   = !masked_q && mode_q[MB_EN] && !tc_q;
  assign step     = req && active && !sel_wr;
  assign addr_inc = mode_q[MB_WIDE] ? ADDR_W'(2) : ADDR_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) masked_q <= 1'b1;
    else if (mask_one || mask_all) masked_q <= 1'b1;
    else if (unmask_one) masked_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
      io_q   <= '0;
      mode_q <= '0;
      tc_q   <= 1'b0;
    end else if (sel_wr) begin
      case (wr.sel)
        RS_IO: begin
          for (int b = 0; b < IO_NB; b++)
            if (wr.idx == 2'(b)) io_q[b*8 +: 8] <= wr.data;
        end
        RS_ADDR: begin
          for (int b = 0; b < ADDR_NB; b++)
            if (wr.idx == 2'(b)) addr_q[b*8 +: 8] <= wr.data;
        end
        RS_CNT: begin
          for (int b = 0; b < CNT_NB; b++)
            if (wr.idx == 2'(b)) cnt_q[b*8 +: 8] <= wr.data;
          tc_q <= 1'b0;
        end
        default: mode_q <= wr.data;
      endcase
    end else if (step) begin
      addr_q <= addr_q + addr_inc;
      cnt_q  <= cnt_q - CNT_W'(1);
      if (cnt_q == '0) tc_q <= 1'b1;
    end
  end

  assert_masked_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !sel_wr) |=> ($stable(cnt_q) && $stable(addr_q)));

  assert_count_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req && active && !sel_wr) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

  assert_tc_stop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    tc_q |-> !active);

  assert_mask_all_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mask_all |=> !active);
endmodule

// File: rtl/dma_cmd_port.sv
module dma_cmd_port
  import dma_cmd_pkg::*;
#(
  parameter int unsigned NCH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_we,
  input  logic              dat_we,
  input  logic              dat_re,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic [NCH-1:0]    xfer_req,
  output logic [NCH-1:0]    chan_active,
  output logic [NCH-1:0]    term_cnt,
  input  logic [CH_W-1:0]   q_chan,
  output logic [MODE_W-1:0] q_mode,
  output logic [IO_W-1:0]   q_io_port,
  output logic [ADDR_W-1:0] q_addr,
  output logic [CNT_W-1:0]  q_count
);
  logic [3:0]      cur_op;
  logic [CH_W-1:0] cur_ch;
  logic [1:0]      ptr;
  byte_wr_t        wr;
  logic            mask_one, unmask_one, mask_all;
  logic [CH_W-1:0] cmd_ch;

  logic [ADDR_W-1:0] addr_a [NCH];
  logic [CNT_W-1:0]  cnt_a  [NCH];
  logic [IO_W-1:0]   io_a   [NCH];
  logic [MODE_W-1:0] mode_a [NCH];

  dma_cmd_decode u_dec (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .dat_we(dat_we), .dat_re(dat_re),
    .wdata(wdata), .cur_op(cur_op), .cur_ch(cur_ch), .ptr(ptr), .wr(wr),
    .mask_one(mask_one), .unmask_one(unmask_one), .mask_all(mask_all), .cmd_ch(cmd_ch)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    dma_chan u_ch (
      .clk(clk), .rst_n(rst_n),
      .sel_wr(wr.en && (cur_ch == CH_W'(g))),
      .wr(wr),
      .mask_one(mask_one && (cmd_ch == CH_W'(g))),
      .unmask_one(unmask_one && (cmd_ch == CH_W'(g))),
      .mask_all(mask_all),
      .req(xfer_req[g]),
      .addr_q(addr_a[g]), .cnt_q(cnt_a[g]), .io_q(io_a[g]), .mode_q(mode_a[g]),
      .tc_q(term_cnt[g]), .active(chan_active[g])
    );
  end

  always_comb begin
    rdata = 8'h00;
    if (32'(cur_ch) < NCH) begin
      if (cur_op == OP_RD_ADDR) begin
        for (int b = 0; b < ADDR_NB; b++)
          if (ptr == 2'(b)) rdata = addr_a[cur_ch][b*8 +: 8];
      end else if (cur_op == OP_RD_CNT) begin
        for (int b = 0; b < CNT_NB; b++)
          if (ptr == 2'(b)) rdata = cnt_a[cur_ch][b*8 +: 8];
      end
    end
  end

  always_comb begin
    q_mode = '0; q_io_port = '0; q_addr = '0; q_count = '0;
    if (32'(q_chan) < NCH) begin
      q_mode    = mode_a[q_chan];
      q_io_port = io_a[q_chan];
      q_addr    = addr_a[q_chan];
      q_count   = cnt_a[q_chan];
    end
  end

  assert_reset_masked_R6: assert property (@(posedge clk)
    !rst_n |=> (chan_active == '0));
endmodule

// File: tb/tb_dma_cmd_port.sv
module tb_dma_cmd_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_we = 0, dat_we = 0, dat_re = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic [15:0] xfer_req = 0, chan_active, term_cnt;
  logic [3:0] q_chan = 0;
  logic [7:0] q_mode;
  logic [15:0] q_io_port, q_count;
  logic [23:0] q_addr;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  dma_cmd_port dut (.*);

  // {kind, data, expected}: kind 0 command, 1 data write, 2 data read
  localparam int NV = 27;
  localparam logic [17:0] VEC [NV] = '{
    {2'd0, 8'h93, 8'h00}, {2'd0, 8'h73, 8'h00}, {2'd1, 8'h4C, 8'h00},
    {2'd0, 8'h23, 8'h00}, {2'd1, 8'h56, 8'h00}, {2'd1, 8'h34, 8'h00},
    {2'd1, 8'h12, 8'h00}, {2'd0, 8'h43, 8'h00}, {2'd1, 8'h03, 8'h00},
    {2'd1, 8'h00, 8'h00}, {2'd0, 8'hA3, 8'h00}, {2'd0, 8'h33, 8'h00},
    {2'd2, 8'h00, 8'h56}, {2'd2, 8'h00, 8'h34}, {2'd2, 8'h00, 8'h12},
    {2'd2, 8'h00, 8'h00}, {2'd0, 8'h53, 8'h00}, {2'd2, 8'h00, 8'h03},
    {2'd2, 8'h00, 8'h00}, {2'd2, 8'h00, 8'h00}, {2'd0, 8'h05, 8'h00},
    {2'd1, 8'hF0, 8'h00}, {2'd1, 8'h03, 8'h00}, {2'd1, 8'hEE, 8'h00},
    {2'd0, 8'h53, 8'h00}, {2'd1, 8'h77, 8'h00}, {2'd2, 8'h00, 8'h03}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cmd(input logic [7:0] b);
    @(negedge clk); cmd_we = 1; wdata = b;
    @(negedge clk); cmd_we = 0;
  endtask

  task automatic wr(input logic [7:0] b);
    @(negedge clk); dat_we = 1; wdata = b;
    @(negedge clk); dat_we = 0;
  endtask

  task automatic rd(input string tag, input logic [7:0] exp);
    @(negedge clk); dat_re = 1;
    chk(tag, rdata, exp);
    @(negedge clk); dat_re = 0;
  endtask

  task automatic req(input int ch);
    @(negedge clk); xfer_req[ch] = 1'b1;
    @(negedge clk); xfer_req = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R6: reset state
    chk("R6 reset active", chan_active, 16'h0);
    chk("R6 reset tc", term_cnt, 16'h0);
    chk("R6 reset count", q_count, 16'h0);
    chk("R7 idle rdata", rdata, 8'h00);

    // R2 R3 R5 R7 R8 table walk
    for (int i = 0; i < NV; i++) begin
      case (VEC[i][17:16])
        2'd0: cmd(VEC[i][15:8]);
        2'd1: wr(VEC[i][15:8]);
        default: rd($sformatf("R2/R3/R7/R8 vec %0d", i), VEC[i][7:0]);
      endcase
    end

    @(negedge clk);
    q_chan = 3;
    #1 chk("R5 mode ch3", q_mode, 8'h4C);
    chk("R2 addr ch3", q_addr, 24'h123456);
    chk("R9 active ch3", chan_active[3], 1'b1);
    q_chan = 5;
    #1 chk("R4 R8 io ch5", q_io_port, 16'h03F0);

    // R10 R11: 16-bit stepping of ch3 from count 3
    q_chan = 3;
    for (int s = 0; s < 3; s++) req(3);
    chk("R10 count after 3", q_count, 16'h0000);
    chk("R10 addr after 3", q_addr, 24'h12345C);
    chk("R11 no tc yet", term_cnt[3], 1'b0);
    req(3);
    chk("R11 wrap count", q_count, 16'hFFFF);
    chk("R11 tc set", term_cnt[3], 1'b1);
    chk("R11 inactive", chan_active[3], 1'b0);
    req(3);
    chk("R11 stopped addr", q_addr, 24'h12345E);
    cmd(8'h43); wr(8'h05); wr(8'h00);
    chk("R3 tc cleared", term_cnt[3], 1'b0);
    chk("R3 count reload", q_count, 16'h0005);

    // R9 masked channel, R10 8-bit step
    q_chan = 5;
    cmd(8'h75); wr(8'h04);
    cmd(8'h45); wr(8'h10); wr(8'h00);
    req(5);
    chk("R9 masked req", q_count, 16'h0010);
    cmd(8'hA5);
    chk("R6 unmask active", chan_active[5], 1'b1);
    req(5);
    chk("R10 8bit count", q_count, 16'h000F);
    chk("R10 8bit addr", q_addr, 24'h000001);

    // R1 pointer restart
    cmd(8'h25); wr(8'hAA);
    cmd(8'h25); wr(8'hBB);
    chk("R1 ptr restart", q_addr, 24'h0000BB);
    cmd(8'h35);
    rd("R1 R7 read b0", 8'hBB);
    rd("R7 read b1", 8'h00);

    // R12 unknown opcode and mask-all
    cmd(8'h65); wr(8'h99);
    chk("R12 unknown count", q_count, 16'h000F);
    chk("R12 unknown active", chan_active[5], 1'b1);
    cmd(8'hD0);
    chk("R12 mask all", chan_active, 16'h0);
    cmd(8'hA5);
    chk("R6 regs kept", q_count, 16'h000F);
    chk("R6 mode kept", q_mode, 8'h04);

    // R9 disabled channel
    q_chan = 7;
    cmd(8'h47); wr(8'h08); wr(8'h00);
    cmd(8'hA7);
    req(7);
    chk("R9 disabled count", q_count, 16'h0008);
    chk("R9 disabled active", chan_active[7], 1'b0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule